// File: doc/BRIEF.md
# Transmit In-Band Command Interpreter

This block sits between a transmit byte queue and an asynchronous serial shifter. It watches the outgoing byte stream for an escape byte (0x00) followed by a command byte. A recognised command either places the line in the break (spacing) condition, releases it, or stalls the stream for a number of millisecond ticks. Every other byte reaches the shifter unchanged. The whole mechanism is gated by an enable input. With the enable low, the block is a plain one-deep pipeline stage.

Both sides use a valid/ready byte handshake. `brk_req` is a level that tells the shifter to hold the line spacing. `busy` reports that a command sequence is in progress.

The controller is a state machine with seven states:

- `ST_IDLE`: forwards bytes.
- `ST_ESC`: an escape has been seen, and the command byte is awaited.
- `ST_LIT2`: the second byte of an unrecognised pair is still owed to the output.
- `ST_DLY_ARG`: the delay count byte is awaited.
- `ST_DELAY`: ticks are being counted.
- `ST_BREAK`: break is on.
- `ST_BRK_ESC`: break is on and an escape has been seen.

Transitions:

- **idle→esc**: escape accepted with the enable high.
- **esc→idle**: escape-escape, or stop-break outside a break.
- **esc→lit2**: unrecognised command byte.
- **esc→dly_arg**: delay command.
- **esc→break**: break command.
- **lit2→idle**: held byte loaded.
- **dly_arg→idle**: count of zero.
- **dly_arg→delay**: non-zero count.
- **delay→idle**: final tick.
- **break→brk_esc**: escape.
- **brk_esc→idle**: stop-break.
- **brk_esc→break**: any other byte.

Top module: `txcmd_interp`

## Requirements
- R1: With `cmd_en` low, every input byte (0x00 included) appears on the output unchanged and in order, one cycle after it is accepted.
- R2: With `cmd_en` high, every non-zero byte received in the idle state is forwarded unchanged and in order, and an escape byte 0x00 alone produces no output.
- R3: The pair 0x00 0x81 raises `brk_req` in the cycle after the 0x81 is accepted.
- R4: While `brk_req` is high, every input byte is consumed and none is forwarded; `out_valid` does not rise.
- R5: The pair 0x00 0x83 during a break lowers `brk_req` and `busy` in the cycle after the 0x83 is accepted, and later data flows again. The same pair outside a break forwards nothing and leaves `brk_req` low.
- R6: The sequence 0x00 0x82 N (N unsigned 8-bit) keeps `in_ready` low and `busy` high until N `ms_tick` pulses have been sampled after the N byte is accepted. The idle state is back in the cycle after the Nth pulse. N = 0 causes no stall.
- R7: The pair 0x00 0x00 forwards exactly one 0x00 byte.
- R8: A pair 0x00 X with X not in {0x00, 0x81, 0x82, 0x83} forwards 0x00 and then X, in that order.
- R9: `busy` is high from the cycle after an escape is accepted until the state machine has returned to idle.
- R10: While `out_valid` is high and `out_ready` low, `out_valid` and `out_data` hold their values.
- R11: After reset, `out_valid`, `brk_req` and `busy` are low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_en | input | 1 | Enables interpretation of escape sequences |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Block can take the input byte |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Byte to the shifter |
| out_ready | input | 1 | Shifter takes the output byte |
| brk_req | output | 1 | Hold the line in the spacing state |
| busy | output | 1 | Command sequence in progress |

## Verification
A forwarded byte sits in the output register one edge after its acceptance, except the second byte of an unrecognised pair, which follows one edge later. `brk_req` and `busy` change at the edge that accepts the final command byte. The end of a delay is seen at the edge that samples the last tick. The bench drives inputs at falling edges and reads each level result one time unit after the rising edge it is due on. It collects forwarded bytes at each handshake edge and compares the full stream only after the pipeline has drained.

// File: rtl/txcmd_pkg.sv
package txcmd_pkg;
    localparam int BYTE_W = 8;

    localparam logic [BYTE_W-1:0] ESC_BYTE    = 8'h00;
    localparam logic [BYTE_W-1:0] CMD_BRK_ON  = 8'h81;
    localparam logic [BYTE_W-1:0] CMD_DELAY   = 8'h82;
    localparam logic [BYTE_W-1:0] CMD_BRK_OFF = 8'h83;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ESC,
        ST_LIT2,
        ST_DLY_ARG,
        ST_DELAY,
        ST_BREAK,
        ST_BRK_ESC
    } ic_state_e;

    typedef enum logic [2:0] {
        K_ESC,
        K_BRK_ON,
        K_DELAY,
        K_BRK_OFF,
        K_OTHER
    } cmd_kind_e;
endpackage

// File: rtl/txcmd_cmd_decode.sv
module txcmd_cmd_decode
    import txcmd_pkg::*;
(
    input  logic [BYTE_W-1:0] code,
    output cmd_kind_e         kind
);
    always_comb begin
        unique case (code)
            ESC_BYTE:    kind = K_ESC;
            CMD_BRK_ON:  kind = K_BRK_ON;
            CMD_DELAY:   kind = K_DELAY;
            CMD_BRK_OFF: kind = K_BRK_OFF;
            default:     kind = K_OTHER;
        endcase
    end
endmodule

// File: rtl/txcmd_tick_timer.sv
module txcmd_tick_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    output logic             expire
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (tick && cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expire = tick && (cnt_q == CNT_W'(1));

    // R6: without a tick or a load the remaining count does not move
    assert_count_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load) |=> $stable(cnt_q));
endmodule

// File: rtl/txcmd_out_slot.sv
module txcmd_out_slot #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_data,
    input  logic         take,
    output logic         valid,
    output logic [W-1:0] data,
    output logic         free
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            data  <= '0;
        end else if (load) begin
            valid <= 1'b1;
            data  <= load_data;
        end else if (take) begin
            valid <= 1'b0;
        end
    end

    assign free = !valid || take;

    // R10: a stalled output byte is held steady
    assert_hold_stalled_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !take) |=> (valid && $stable(data)));
endmodule

// File: rtl/txcmd_interp.sv
module txcmd_interp
    import txcmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_en,
    input  logic              ms_tick,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    output logic              in_ready,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_data,
    input  logic              out_ready,
    output logic              brk_req,
    output logic              busy
);
    localparam int DLY_W = BYTE_W;

    ic_state_e         state_q, state_d;
    logic [BYTE_W-1:0] held_q, held_d;
    cmd_kind_e         kind;
    logic              accept;
    logic              slot_load, slot_free;
    logic [BYTE_W-1:0] slot_data;
    logic              tmr_load, tmr_expire;

    assign accept = in_valid && in_ready;

    txcmd_cmd_decode u_dec (
        .code (in_data),
        .kind (kind)
    );

    txcmd_tick_timer #(.CNT_W(DLY_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (in_data[DLY_W-1:0]),
        .tick     (ms_tick),
        .expire   (tmr_expire)
    );

    txcmd_out_slot #(.W(BYTE_W)) u_slot (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (slot_load),
        .load_data (slot_data),
        .take      (out_ready),
        .valid     (out_valid),
        .data      (out_data),
        .free      (slot_free)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            held_q  <= '0;
        end else begin
            state_q <= state_d;
            held_q  <= held_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        held_d  = held_q;
        unique case (state_q)
            ST_IDLE: if (accept && cmd_en && in_data == ESC_BYTE) state_d = ST_ESC;
            ST_ESC: if (accept) begin
                unique case (kind)
                    K_ESC:     state_d = ST_IDLE;
                    K_BRK_ON:  state_d = ST_BREAK;
                    K_DELAY:   state_d = ST_DLY_ARG;
                    K_BRK_OFF: state_d = ST_IDLE;
                    default: begin
                        state_d = ST_LIT2;
                        held_d  = in_data;
                    end
                endcase
            end
            ST_LIT2:    if (slot_free) state_d = ST_IDLE;
            ST_DLY_ARG: if (accept) state_d = (in_data == '0) ? ST_IDLE : ST_DELAY;
            ST_DELAY:   if (tmr_expire) state_d = ST_IDLE;
            ST_BREAK:   if (accept && in_data == ESC_BYTE) state_d = ST_BRK_ESC;
            ST_BRK_ESC: if (accept) state_d = (in_data == CMD_BRK_OFF) ? ST_IDLE : ST_BREAK;
            default:    state_d = ST_IDLE;
        endcase
    end

    // outputs and datapath controls
    always_comb begin
        in_ready  = 1'b0;
        slot_load = 1'b0;
        slot_data = in_data;
        tmr_load  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                in_ready  = slot_free;
                slot_load = accept && !(cmd_en && in_data == ESC_BYTE);
            end
            ST_ESC: begin
                in_ready = !out_valid;
                if (accept && (kind == K_ESC || kind == K_OTHER)) begin
                    slot_load = 1'b1;
                    slot_data = ESC_BYTE;
                end
            end
            ST_LIT2: begin
                slot_load = slot_free;
                slot_data = held_q;
            end
            ST_DLY_ARG: begin
                in_ready = 1'b1;
                tmr_load = accept && in_data != '0;
            end
            ST_DELAY:   in_ready = 1'b0;
            ST_BREAK:   in_ready = 1'b1;
            ST_BRK_ESC: in_ready = 1'b1;
            default:    in_ready = 1'b0;
        endcase
    end

    assign busy    = (state_q != ST_IDLE);
    assign brk_req = (state_q == ST_BREAK) || (state_q == ST_BRK_ESC);

    // R3: break starts only on an accepted break command byte
    assert_brk_rise_cmd_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(brk_req) |-> $past(accept && in_data == CMD_BRK_ON));

    // R5: break ends only on an accepted stop command byte
    assert_brk_fall_cmd_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(brk_req) |-> $past(accept && in_data == CMD_BRK_OFF));

    // R4: nothing new is presented while the line is in break
    assert_quiet_in_break_R4: assert property (@(posedge clk) disable iff (!rst_n)
        brk_req |=> !$rose(out_valid));

    // R1: transparent forwarding with interpretation disabled
    assert_transparent_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !cmd_en && accept) |=> (out_valid && out_data == $past(in_data)));

    // R6: a delay ends only on a tick
    assert_delay_needs_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DELAY && !ms_tick) |=> (state_q == ST_DELAY && !in_ready));
endmodule

// File: tb/txcmd_interp_tb.sv
module txcmd_interp_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_en = 1'b0;
    logic       ms_tick = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_ready;
    logic       out_valid;
    logic [7:0] out_data;
    logic       out_ready = 1'b1;
    logic       brk_req;
    logic       busy;

    int vecs = 0;
    int errs = 0;
    int rx_n = 0;
    int exp_n = 0;
    int vfrom = 0;
    bit finished = 1'b0;
    logic [7:0] rx_q  [0:2047];
    logic [7:0] exp_q [0:2047];

    always #5 clk = ~clk;

    txcmd_interp u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_en(cmd_en), .ms_tick(ms_tick),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
        .brk_req(brk_req), .busy(busy)
    );

    always @(posedge clk) begin
        if (rst_n && out_valid && out_ready) begin
            rx_q[rx_n] <= out_data;
            rx_n <= rx_n + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vecs++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic expect_byte(input logic [7:0] b);
        exp_q[exp_n] = b;
        exp_n++;
    endtask

    // drive one byte; returns one time unit after the accepting edge
    task automatic put(input logic [7:0] b);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = b;
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    task automatic pulse_tick();
        @(negedge clk);
        ms_tick = 1'b1;
        @(posedge clk);
        #1;
        ms_tick = 1'b0;
    endtask

    task automatic verify_stream(input string req);
        repeat (6) @(posedge clk);
        @(negedge clk);
        chk(rx_n == exp_n, req, rx_n, exp_n);
        for (int i = vfrom; i < exp_n && i < rx_n; i++)
            chk(rx_q[i] == exp_q[i], req, rx_q[i], exp_q[i]);
        vfrom = exp_n;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R11 reset state
        chk(!out_valid, "R11", out_valid, 0);
        chk(!brk_req, "R11", brk_req, 0);
        chk(!busy, "R11", busy, 0);
        chk(in_ready, "R11", in_ready, 1);

        // R1: interpretation off, every value passes
        cmd_en = 1'b0;
        for (int v = 0; v < 256; v++) begin
            put(8'(v));
            expect_byte(8'(v));
        end
        put(8'h00); expect_byte(8'h00);
        put(8'h81); expect_byte(8'h81);
        verify_stream("R1");

        // R2: interpretation on, plain bytes pass
        cmd_en = 1'b1;
        for (int v = 1; v < 256; v++) begin
            put(8'(v));
            expect_byte(8'(v));
        end
        verify_stream("R2");

        // R9 and R2: a lone escape produces nothing and sets busy
        put(8'h00);
        chk(busy, "R9", busy, 1);
        repeat (4) @(posedge clk);
        #1;
        chk(rx_n == exp_n, "R2", rx_n, exp_n);
        // R7: completing with another escape gives one literal zero
        put(8'h00);
        chk(!busy, "R9", busy, 0);
        expect_byte(8'h00);
        verify_stream("R7");

        // R8: unrecognised command bytes are forwarded as a pair
        for (int v = 1; v < 256; v++) begin
            if (v >= 8'h81 && v <= 8'h83) continue;
            put(8'h00);
            put(8'(v));
            expect_byte(8'h00);
            expect_byte(8'(v));
        end
        verify_stream("R8");

        // R5: stop-break outside a break has no effect
        put(8'h00);
        put(8'h83);
        chk(!brk_req, "R5", brk_req, 0);
        chk(!busy, "R5", busy, 0);
        verify_stream("R5");

        // R3: break on
        put(8'h00);
        put(8'h81);
        chk(brk_req, "R3", brk_req, 1);
        chk(busy, "R3", busy, 1);
        // R4: data, a literal escape pair and a delay command are all absorbed
        put(8'h55); put(8'h00); put(8'h00); put(8'h12);
        put(8'h00); put(8'h82); put(8'hAA);
        repeat (3) @(posedge clk);
        #1;
        chk(!out_valid, "R4", out_valid, 0);
        chk(brk_req, "R4", brk_req, 1);
        verify_stream("R4");
        // R5: stop-break releases the line
        put(8'h00);
        put(8'h83);
        chk(!brk_req, "R5", brk_req, 0);
        chk(!busy, "R5", busy, 0);
        put(8'h42);
        expect_byte(8'h42);
        verify_stream("R5");

        // R6: delays of several lengths
        for (int n = 1; n <= 5; n++) begin
            put(8'h00);
            put(8'h82);
            put(8'(n));
            chk(busy && !in_ready, "R6", {busy, in_ready}, 2'b10);
            for (int t = 1; t < n; t++) begin
                repeat (3) @(posedge clk);
                pulse_tick();
                chk(busy && !in_ready, "R6", {busy, in_ready}, 2'b10);
            end
            repeat (7) @(posedge clk);
            #1;
            chk(busy, "R6", busy, 1);
            pulse_tick();
            chk(!busy && in_ready, "R6", {busy, in_ready}, 2'b01);
            put(8'(8'h10 + n));
            expect_byte(8'(8'h10 + n));
        end
        // R6: zero count causes no stall
        put(8'h00);
        put(8'h82);
        put(8'h00);
        chk(!busy && in_ready, "R6", {busy, in_ready}, 2'b01);
        verify_stream("R6");

        // R10: stalled output holds
        out_ready = 1'b0;
        put(8'h3C);
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            chk(out_valid && out_data == 8'h3C, "R10", out_data, 8'h3C);
        end
        out_ready = 1'b1;
        expect_byte(8'h3C);
        verify_stream("R10");

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            vecs++;
            errs++;
            $display("FAIL watchdog: actual=%0h expected=%0h", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
            $finish;
        end
    end
endmodule